// File: doc/BRIEF.md
# Power-of-Two Input Debounce Filter

This block cleans up one general-purpose input line before the line reaches edge detection. It takes an input that has already been synchronized to the clock, plus a strobe that pulses once per millisecond. The filtered output takes a new level only after the raw input has held that level for 2^code consecutive millisecond strobes. The code can select a hold time from 1 ms to 128 ms. A one-cycle change pulse marks every movement of the filtered output, so logic further down can detect edges without keeping its own copy of the previous level.

The control arrives as a small field cut from the line's control word. With default parameters this field is control-word bits [8:5]. The top bit of the field (control-word bit 8) switches the filter on. The bits below it hold the exponent. When the filter is off, the output follows the raw input with one clock of delay and ignores the strobe. Software rounds a requested time to the nearest power of two before it writes the exponent.

Top module: `pow2_debounce`

## Requirements
- R1: While reset is held, `filt_o` and `chg_o` are 0. On the first clock edge after reset is released, `filt_o` takes the raw input level, and `chg_o` stays 0 on that edge.
- R2: Field bit FIELD_W-1 (control-word bit 8 with defaults) is the enable. Field bits [FIELD_W-2:0] (control-word bits [7:5]) hold the exponent. Field value 4'b1_eee enables the filter with exponent eee.
- R3: While the enable bit is 0, `filt_o` equals the raw input of the previous clock, whatever `tick_i` does.
- R4: While enabled, a new raw level reaches `filt_o` on the clock edge that carries the 2^e-th tick strobe after the change. The level must stay stable through all those ticks, and e is the exponent.
- R5: Any change of the raw input restarts the count. A strobe that falls in the same cycle as a raw change is not counted.
- R6: A change of the exponent while a count is running restarts the count. The new period is counted from the next strobe.
- R7: An exponent above MAX_EXP (7) behaves as MAX_EXP, giving 128 strobes.
- R8: `chg_o` is 1 for exactly the one cycle after each edge on which `filt_o` changed, and 0 otherwise.
- R9: While enabled, `filt_o` changes only on an edge where `tick_i` is 1, and then only to the raw level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Synchronized raw input level |
| tick_i | input | 1 | One-cycle strobe once per millisecond |
| dbc_field_i | input | FIELD_W | Enable (top bit) and exponent (lower bits) |
| filt_o | output | 1 | Filtered level |
| chg_o | output | 1 | One-cycle pulse when `filt_o` changes |

## Verification
Three events can fall in the same cycle as a tick strobe: a raw-input change, an exponent change, or the strobe that should complete the count. The priority between them decides whether the count restarts or completes. The bench forces a raw change onto a strobe cycle with exponent 0 and expects no output movement until the following strobe. It also changes the exponent partway through a count and expects the full new period from the next strobe. A sweep over every exponent, in both directions, checks the completing strobe against 2^e. A second instance with a wider field checks the saturation.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

   // Where the next filtered level comes from.
   typedef enum logic [1:0] {
      SRC_HOLD   = 2'd0,
      SRC_PRIME  = 2'd1,
      SRC_BYPASS = 2'd2,
      SRC_SETTLE = 2'd3
   } dbn_src_e;

   // The counter must reach 2^max_exp.
   function automatic int unsigned cnt_width(input int unsigned max_exp);
      return max_exp + 1;
   endfunction

endpackage

// File: rtl/dbn_field_decode.sv
module dbn_field_decode #(
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned MAX_EXP = 7,
   localparam int unsigned EXP_W = FIELD_W - 1
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic               en_o,
   output logic [EXP_W-1:0]   exp_o
);

   localparam int unsigned CODE_TOP = (1 << EXP_W) - 1;

   logic [EXP_W-1:0] raw_exp;

   assign en_o    = field_i[FIELD_W-1];
   assign raw_exp = field_i[EXP_W-1:0];

   generate
      if (FIELD_W < 2) begin : g_bad_field
         $error("dbn_field_decode: FIELD_W must be at least 2");
      end
      if (CODE_TOP > MAX_EXP) begin : g_sat
         // Codes above the limit saturate.
         assign exp_o = (raw_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : raw_exp;
      end else begin : g_pass
         assign exp_o = raw_exp;
      end
   endgenerate

endmodule

// File: rtl/dbn_stable_cnt.sv
module dbn_stable_cnt #(
   parameter int unsigned EXP_W = 3,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             hit_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] target;

   assign target  = CNT_W'(1) << exp_i;
   assign cnt_inc = cnt_q + CNT_W'(1);
   assign hit_o   = step_i & ~clear_i & (cnt_inc == target);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= hit_o ? '0 : cnt_inc;
      end
   end

endmodule

// File: rtl/pow2_debounce.sv
module pow2_debounce #(
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned MAX_EXP = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               raw_i,
   input  logic               tick_i,
   input  logic [FIELD_W-1:0] dbc_field_i,
   output logic               filt_o,
   output logic               chg_o
);

   import dbn_pkg::*;

   localparam int unsigned EXP_W = FIELD_W - 1;
   localparam int unsigned CNT_W = cnt_width(MAX_EXP);

   generate
      if (MAX_EXP > 24) begin : g_bad_exp
         $error("pow2_debounce: MAX_EXP above 24 is not supported");
      end
   endgenerate

   logic             en;
   logic [EXP_W-1:0] exp_w;
   logic             prev_q;
   logic [EXP_W-1:0] code_q;
   logic             primed_q;
   logic             out_q;
   logic             chg_q;
   logic             clear;
   logic             hit;
   dbn_src_e         src;

   dbn_field_decode #(
      .FIELD_W (FIELD_W),
      .MAX_EXP (MAX_EXP)
   ) u_decode (
      .field_i (dbc_field_i),
      .en_o    (en),
      .exp_o   (exp_w)
   );

   // Restart on: bypass, first cycle, raw change, exponent change, or no pending change.
   assign clear = ~en | ~primed_q | (raw_i != prev_q) | (exp_w != code_q) | (raw_i == out_q);

   dbn_stable_cnt #(
      .EXP_W (EXP_W),
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .step_i  (tick_i),
      .exp_i   (exp_w),
      .hit_o   (hit)
   );

   always_comb begin
      if (!primed_q)  src = SRC_PRIME;
      else if (!en)   src = SRC_BYPASS;
      else if (hit)   src = SRC_SETTLE;
      else            src = SRC_HOLD;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q   <= 1'b0;
         code_q   <= '0;
         primed_q <= 1'b0;
         out_q    <= 1'b0;
         chg_q    <= 1'b0;
      end else begin
         prev_q   <= raw_i;
         code_q   <= exp_w;
         primed_q <= 1'b1;
         unique case (src)
            SRC_PRIME: begin
               out_q <= raw_i;
               chg_q <= 1'b0;
            end
            SRC_BYPASS: begin
               out_q <= raw_i;
               chg_q <= (raw_i != out_q);
            end
            SRC_SETTLE: begin
               out_q <= raw_i;
               chg_q <= 1'b1;
            end
            default: begin
               chg_q <= 1'b0;
            end
         endcase
      end
   end

   assign filt_o = out_q;
   assign chg_o  = chg_q;

endmodule

// File: rtl/pow2_debounce_chk.sv
module pow2_debounce_chk #(
   parameter int unsigned FIELD_W = 4
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               raw_i,
   input logic               tick_i,
   input logic [FIELD_W-1:0] dbc_field_i,
   input logic               filt_o,
   input logic               chg_o
);

   logic live_q;
   logic live2_q;
   logic en_c;

   assign en_c = dbc_field_i[FIELD_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         live_q  <= 1'b0;
         live2_q <= 1'b0;
      end else begin
         live_q  <= 1'b1;
         live2_q <= live_q;
      end
   end

   a_r1_first_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !live_q |=> (filt_o == $past(raw_i)) && !chg_o);

   a_r3_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && !en_c) |=> filt_o == $past(raw_i));

   a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && en_c && !tick_i) |=> $stable(filt_o));

   a_r9_only_to_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && en_c) |=> (filt_o == $past(filt_o)) || (filt_o == $past(raw_i)));

   a_r8_pulse_marks_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_o |-> filt_o != $past(filt_o));

   a_r8_change_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live2_q && (filt_o != $past(filt_o))) |-> chg_o);

endmodule

bind pow2_debounce pow2_debounce_chk #(.FIELD_W(FIELD_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .raw_i       (raw_i),
   .tick_i      (tick_i),
   .dbc_field_i (dbc_field_i),
   .filt_o      (filt_o),
   .chg_o       (chg_o)
);

// File: tb/pow2_debounce_tb_top.sv
`timescale 1ns/1ps
module pow2_debounce_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       raw = 1'b1;
   logic       tick = 1'b0;
   logic [3:0] field = 4'b1_011;
   logic       filt;
   logic       chg;
   logic       raw_s = 1'b0;
   logic [4:0] field_s = 5'b1_0000;
   logic       filt_s;
   logic       chg_s;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pow2_debounce dut_i (
      .clk_i (clk), .rst_ni (rst_n), .raw_i (raw), .tick_i (tick),
      .dbc_field_i (field), .filt_o (filt), .chg_o (chg)
   );

   pow2_debounce #(.FIELD_W(5), .MAX_EXP(7)) dut_s (
      .clk_i (clk), .rst_ni (rst_n), .raw_i (raw_s), .tick_i (tick),
      .dbc_field_i (field_s), .filt_o (filt_s), .chg_o (chg_s)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic one_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      logic cur;
      idle(2);
      // R1: held in reset
      chk(filt == 1'b0 && chg == 1'b0, "R1 reset state", {filt, chg}, 0);
      rst_n = 1'b1;
      idle(1);
      chk(filt == 1'b1, "R1 first sample", filt, 1);
      chk(chg == 1'b0, "R1 no pulse on prime", chg, 0);
      idle(1);
      chk(chg == 1'b0, "R1 no later pulse", chg, 0);

      // R3 bypass: enable bit clear, no ticks
      field = 4'b0_111;
      idle(1);
      for (int k = 0; k < 3; k++) begin
         raw = ~raw;
         idle(1);
         chk(filt == raw, "R3 bypass follows", filt, raw);
         chk(chg == 1'b1, "R8 bypass pulse", chg, 1);
         idle(1);
         chk(chg == 1'b0, "R8 bypass pulse ends", chg, 0);
      end

      // R2/R4 sweep over every exponent and both directions
      for (int e = 0; e < 8; e++) begin
         for (int d = 0; d < 2; d++) begin
            int n;
            n = 1 << e;
            field = {1'b1, 3'(e)};
            idle(1);
            cur = filt;
            raw = ~cur;
            idle(1);
            for (int k = 1; k < n; k++) begin
               one_tick();
               idle(1);
            end
            chk(filt == cur, $sformatf("R2,R4 exp %0d before last tick", e), filt, cur);
            one_tick();
            chk(filt == ~cur, $sformatf("R4 exp %0d on tick %0d", e, n), filt, ~cur);
            chk(chg == 1'b1, "R8 settle pulse", chg, 1);
            idle(1);
            chk(chg == 1'b0, "R8 settle pulse ends", chg, 0);
         end
      end

      // R5: glitch restarts the count (exp 2 -> 4 ticks)
      field = 4'b1_010;
      idle(1);
      cur = filt;
      raw = ~cur;
      idle(1);
      for (int k = 0; k < 3; k++) begin one_tick(); idle(1); end
      raw = cur;
      idle(1);
      raw = ~cur;
      idle(1);
      for (int k = 0; k < 3; k++) begin one_tick(); idle(1); end
      chk(filt == cur, "R5 glitch restarted count", filt, cur);
      one_tick();
      chk(filt == ~cur, "R5 settles after full period", filt, ~cur);
      idle(1);

      // R5: strobe in the change cycle is not counted (exp 0)
      field = 4'b1_000;
      idle(1);
      cur = filt;
      raw = ~cur;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk(filt == cur, "R5 coincident tick ignored", filt, cur);
      idle(1);
      one_tick();
      chk(filt == ~cur, "R5 next tick settles", filt, ~cur);
      idle(1);

      // R6: exponent change mid count (exp 3 then exp 2)
      field = 4'b1_011;
      idle(1);
      cur = filt;
      raw = ~cur;
      idle(1);
      for (int k = 0; k < 5; k++) begin one_tick(); idle(1); end
      field = 4'b1_010;
      idle(1);
      for (int k = 0; k < 3; k++) begin one_tick(); idle(1); end
      chk(filt == cur, "R6 restart after exponent change", filt, cur);
      one_tick();
      chk(filt == ~cur, "R6 new period completes", filt, ~cur);
      idle(1);

      // R7: saturation on the wide-field instance (codes 9 and 15 -> 128)
      for (int c = 0; c < 2; c++) begin
         field_s = {1'b1, (c == 0) ? 4'd9 : 4'd15};
         idle(1);
         cur = filt_s;
         raw_s = ~cur;
         idle(1);
         for (int k = 1; k < 128; k++) begin one_tick(); idle(1); end
         chk(filt_s == cur, "R7 saturated code before tick 128", filt_s, cur);
         one_tick();
         chk(filt_s == ~cur, "R7 saturated code at tick 128", filt_s, ~cur);
         chk(chg_s == 1'b1, "R8 saturated pulse", chg_s, 1);
         idle(1);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule